// File: doc/BRIEF.md
# Write-Data Scheduler for a DDR PHY Data Path

This block turns write commands from a memory controller into correctly timed write-data traffic toward a DDR PHY. Each command opens a burst of a fixed number of beats. The per-slice write-data enables, and the matching ECC enable, rise a programmable write latency after the command. They stay high for the whole contiguous run of beats.

The data itself, with its byte mask, ECC code and ECC mask, follows the enable by a second programmable offset. An offset of zero places data in the same cycle as the enable. Beats are taken from a show-ahead source that holds one beat per cycle, and the block pops the source exactly on the cycles when a beat is due.

The byte mask has one bit per 8 data bits. When the data width is not a whole number of bytes, the most significant mask bit covers the partial top byte. If the source is empty when a beat is due, the block still spends the slot. It flags the beat as an underflow and masks every byte of it.

Top module: `wdata_sched`

## Requirements
- R1: When `wr_cmd` is high in cycle t, every bit of `phy_wd_en` is high in cycles t+`cfg_wrlat` through t+`cfg_wrlat`+BURST-1 (BURST = 4 by default), and low otherwise when no other command is in flight. A `cfg_wrlat` of 0 raises the enable in cycle t itself.
- R2: A data beat is due in cycle c exactly when `phy_wd_en` was high in cycle c-`cfg_wrdata`. So the beat run starts `cfg_wrdata` cycles after the enable rises and is exactly as long as the enable run. A `cfg_wrdata` of 0 puts each beat in the same cycle as its enable.
- R3: Commands issued exactly BURST cycles apart produce one unbroken enable run of 2×BURST cycles and an unbroken beat run of the same length.
- R4: All SLICES bits of `phy_wd_en` are always equal, and `phy_wecc_en` always equals them.
- R5: In a due cycle with `src_valid` high, `src_ready` is high and `phy_wd`, `phy_wd_mask`, `phy_wecc` and `phy_wecc_mask` equal the source fields of that same cycle unchanged.
- R6: `phy_wd_mask` is ceil(DATA_W/8) bits wide (5 bits for the default DATA_W = 36). Bit i qualifies data bits [8i+7:8i], and bit 4 qualifies the 4-bit partial byte [35:32]. The ECC mask follows the same rule for ECC_W (2 bits for ECC_W = 12).
- R7: In a due cycle with `src_valid` low, `underflow` is high, `phy_wd_mask` and `phy_wecc_mask` are all ones, and `phy_wd` and `phy_wecc` are zero.
- R8: Outside due cycles, `src_ready` and `underflow` are low, and `phy_wd`, `phy_wd_mask`, `phy_wecc` and `phy_wecc_mask` are zero, whatever the source presents.
- R9: While `rst_n` is low with `wr_cmd` held low, all enables, `src_ready` and `underflow` are low, and a reset in the middle of a burst discards every pending enable and beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wrlat | input | 4 | Cycles from command to enable; static while traffic is in flight |
| cfg_wrdata | input | 3 | Cycles from enable to data; static while traffic is in flight |
| wr_cmd | input | 1 | Write command, one cycle per burst |
| src_valid | input | 1 | Source holds a beat |
| src_data | input | 36 | Source write data |
| src_mask | input | 5 | Source byte mask (1 = byte masked) |
| src_ecc | input | 12 | Source ECC code |
| src_ecc_mask | input | 2 | Source ECC byte mask |
| src_ready | output | 1 | Pop strobe, high in each due cycle |
| phy_wd_en | output | 4 | Per-slice write-data enable |
| phy_wecc_en | output | 1 | ECC enable |
| phy_wd | output | 36 | Write data to PHY |
| phy_wd_mask | output | 5 | Write byte mask to PHY |
| phy_wecc | output | 12 | ECC code to PHY |
| phy_wecc_mask | output | 2 | ECC byte mask to PHY |
| underflow | output | 1 | Due beat found the source empty |

## Verification
A table of single-command cases sweeps the two latencies across zero, small, mixed and maximum settings. Zero-zero tells a same-cycle path apart from a registered one. Unequal pairs show whether the two offsets are added or confused with each other. The maximum write latency exposes tap-selection errors at the top of the delay line.

Underflow patterns inside the burst (first, middle, last beat) separate a per-beat decision from a per-burst one. Directed cases cover commands spaced exactly one burst apart, a source that stays valid while no beat is due, and a reset in the middle of a burst. They tell apart a merge of back-to-back runs, a pop outside due cycles, and state that survives reset.

// File: rtl/wds_pkg.sv
// Package: shared sizing helpers for the write-data scheduler.
// Assumes: widths are positive; a mask bit covers 8 data bits, the top
// bit covering any partial byte.
package wds_pkg;

    // Number of mask bits needed for a field of w bits (ceil(w/8)).
    function automatic int mask_bits(input int w);
        return (w + 7) / 8;
    endfunction

    // Counter width able to hold values 0..n.
    function automatic int cnt_bits(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/wds_burst.sv
// Module: wds_burst
// Expands a one-cycle write command into a run of BURST cycles.
// Assumes: a new command arrives only once the previous run has reached its
// last cycle, so commands BURST cycles apart merge into one unbroken run.
module wds_burst #(
    parameter int BURST = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    output logic run
);
    localparam int CNT_W = wds_pkg::cnt_bits(BURST);

    logic [CNT_W-1:0] remain;

    // Count the cycles still owed to the current run after this one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (cmd)
            remain <= CNT_W'(BURST - 1);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    // The run is live in the command cycle and while cycles remain owed.
    always_comb run = cmd || (remain != '0);

    AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        cmd |-> (remain == '0)); // R3

    generate
        if (BURST > 1) begin : g_len
            AST_RUN_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
                cmd |=> run); // R1
        end
    endgenerate
endmodule

// File: rtl/wds_delay.sv
// Module: wds_delay
// Delays a single-bit stream by a run-time selected number of cycles.
// A selection of 0 passes the input straight through.
// Assumes: sel is static while ones are travelling through the line.
module wds_delay #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             d,
    input  logic [SEL_W-1:0] sel,
    output logic             q
);
    localparam int DEPTH = 1 << SEL_W;

    logic [DEPTH-1:0] sr;
    logic [SEL_W-1:0] tap;
    logic             live;

    // Shift the stream one stage per cycle; reset empties the line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr <= '0;
        else
            sr <= {sr[DEPTH-2:0], d};
    end

    // Mark that at least one cycle has passed since reset, for the checks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            live <= 1'b0;
        else
            live <= 1'b1;
    end

    // Pick the stage matching the requested delay.
    always_comb begin
        tap = sel - 1'b1;
        q   = (sel == '0) ? d : sr[tap];
    end

    AST_TAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (live && sel == SEL_W'(1) && $past(sel) == SEL_W'(1)) |-> (q == $past(d))); // R1

    AST_TAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> (q == d)); // R2
endmodule

// File: rtl/wds_beat.sv
// Module: wds_beat
// Forms the beat presented to the PHY: passes source fields in a due cycle,
// masks everything on underflow, drives zeros when no beat is due.
// Assumes: the source is show-ahead; src_ready pops it at the clock edge.
module wds_beat #(
    parameter int DATA_W = 36,
    parameter int ECC_W  = 12
) (
    input  logic                                  due,
    input  logic                                  src_valid,
    input  logic [DATA_W-1:0]                     src_data,
    input  logic [wds_pkg::mask_bits(DATA_W)-1:0] src_mask,
    input  logic [ECC_W-1:0]                      src_ecc,
    input  logic [wds_pkg::mask_bits(ECC_W)-1:0]  src_ecc_mask,
    output logic                                  src_ready,
    output logic                                  underflow,
    output logic [DATA_W-1:0]                     wd,
    output logic [wds_pkg::mask_bits(DATA_W)-1:0] wd_mask,
    output logic [ECC_W-1:0]                      wecc,
    output logic [wds_pkg::mask_bits(ECC_W)-1:0]  wecc_mask
);
    localparam int MASK_W  = wds_pkg::mask_bits(DATA_W);
    localparam int EMASK_W = wds_pkg::mask_bits(ECC_W);

    logic take;

    // Decide whether this cycle carries real data, an empty slot or nothing.
    always_comb begin
        take      = due && src_valid;
        src_ready = due;
        underflow = due && !src_valid;
    end

    // Steer data and masks: pass-through, fully masked, or quiet zeros.
    always_comb begin
        wd        = take ? src_data     : '0;
        wecc      = take ? src_ecc      : '0;
        wd_mask   = take ? src_mask     : (underflow ? {MASK_W{1'b1}}  : '0);
        wecc_mask = take ? src_ecc_mask : (underflow ? {EMASK_W{1'b1}} : '0);
    end
endmodule

// File: rtl/wdata_sched.sv
// Module: wdata_sched (top)
// Schedules write-data enables and beats toward a DDR PHY: enable follows a
// command by cfg_wrlat cycles, data follows the enable by cfg_wrdata cycles.
// Assumes: both latencies are static while traffic is in flight; commands
// are at least BURST cycles apart.
module wdata_sched #(
    parameter int DATA_W     = 36,
    parameter int ECC_W      = 12,
    parameter int SLICES     = 4,
    parameter int BURST      = 4,
    parameter int MAX_WRLAT  = 15,
    parameter int MAX_WRDATA = 7
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [wds_pkg::cnt_bits(MAX_WRLAT)-1:0]  cfg_wrlat,
    input  logic [wds_pkg::cnt_bits(MAX_WRDATA)-1:0] cfg_wrdata,
    input  logic                                  wr_cmd,
    input  logic                                  src_valid,
    input  logic [DATA_W-1:0]                     src_data,
    input  logic [wds_pkg::mask_bits(DATA_W)-1:0] src_mask,
    input  logic [ECC_W-1:0]                      src_ecc,
    input  logic [wds_pkg::mask_bits(ECC_W)-1:0]  src_ecc_mask,
    output logic                                  src_ready,
    output logic [SLICES-1:0]                     phy_wd_en,
    output logic                                  phy_wecc_en,
    output logic [DATA_W-1:0]                     phy_wd,
    output logic [wds_pkg::mask_bits(DATA_W)-1:0] phy_wd_mask,
    output logic [ECC_W-1:0]                      phy_wecc,
    output logic [wds_pkg::mask_bits(ECC_W)-1:0]  phy_wecc_mask,
    output logic                                  underflow
);
    localparam int LAT_W  = wds_pkg::cnt_bits(MAX_WRLAT);
    localparam int OFS_W  = wds_pkg::cnt_bits(MAX_WRDATA);
    localparam int PEND_W = wds_pkg::cnt_bits(MAX_WRDATA + 1);

    logic run;
    logic en;
    logic due;
    logic [PEND_W-1:0] pending;

    // Stage 1: command to burst run.
    wds_burst #(.BURST(BURST)) u_burst (
        .clk(clk), .rst_n(rst_n), .cmd(wr_cmd), .run(run)
    );

    // Stage 2: run delayed by the write latency gives the enable.
    wds_delay #(.SEL_W(LAT_W)) u_lat (
        .clk(clk), .rst_n(rst_n), .d(run), .sel(cfg_wrlat), .q(en)
    );

    // Stage 3: enable delayed by the data offset marks due beats.
    wds_delay #(.SEL_W(OFS_W)) u_ofs (
        .clk(clk), .rst_n(rst_n), .d(en), .sel(cfg_wrdata), .q(due)
    );

    // Stage 4: beat formation from the source.
    wds_beat #(.DATA_W(DATA_W), .ECC_W(ECC_W)) u_beat (
        .due(due), .src_valid(src_valid), .src_data(src_data),
        .src_mask(src_mask), .src_ecc(src_ecc), .src_ecc_mask(src_ecc_mask),
        .src_ready(src_ready), .underflow(underflow), .wd(phy_wd),
        .wd_mask(phy_wd_mask), .wecc(phy_wecc), .wecc_mask(phy_wecc_mask)
    );

    // Fan the enable out to every data slice and to the ECC lane.
    always_comb begin
        phy_wd_en   = {SLICES{en}};
        phy_wecc_en = en;
    end

    // Track beats announced by the enable but not yet delivered.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= '0;
        else
            case ({en, due})
                2'b10:   pending <= pending + 1'b1;
                2'b01:   pending <= pending - 1'b1;
                default: pending <= pending;
            endcase
    end

    AST_BEAT_HAS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        due |-> (pending != '0 || en)); // R2

    AST_PENDING_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= PEND_W'(MAX_WRDATA)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !due |-> (phy_wd == '0 && phy_wd_mask == '0 && !underflow && !src_ready)); // R8

    AST_UNDERFLOW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (&phy_wd_mask && &phy_wecc_mask && phy_wd == '0)); // R7

    AST_ECC_EN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_wecc_en == phy_wd_en[SLICES-1]) && (phy_wd_en == '0 || &phy_wd_en)); // R4
endmodule

// File: tb/wdata_sched_test.sv
`timescale 1ns/1ps
module wdata_sched_test;
    localparam int DATA_W = 36;
    localparam int ECC_W  = 12;
    localparam int SLICES = 4;
    localparam int BURST  = 4;
    localparam int MW     = 5;
    localparam int EMW    = 2;
    localparam int NC     = 48;
    localparam int NV     = 7;

    // Stimulus table: write latency, data offset, underflow beats (bit = beat index).
    localparam int V_LAT[NV] = '{0, 1, 3, 5, 2, 15, 0};
    localparam int V_OFS[NV] = '{0, 0, 2, 7, 1, 3, 5};
    localparam int V_UF [NV] = '{0, 0, 0, 4, 9, 0, 8};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] cfg_wrlat = '0;
    logic [2:0] cfg_wrdata = '0;
    logic wr_cmd = 1'b0;
    logic src_valid = 1'b0;
    logic [DATA_W-1:0] src_data = '0;
    logic [MW-1:0] src_mask = '0;
    logic [ECC_W-1:0] src_ecc = '0;
    logic [EMW-1:0] src_ecc_mask = '0;
    logic src_ready, phy_wecc_en, underflow;
    logic [SLICES-1:0] phy_wd_en;
    logic [DATA_W-1:0] phy_wd;
    logic [MW-1:0] phy_wd_mask;
    logic [ECC_W-1:0] phy_wecc;
    logic [EMW-1:0] phy_wecc_mask;

    int nchecks = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    wdata_sched uut (
        .clk(clk), .rst_n(rst_n), .cfg_wrlat(cfg_wrlat), .cfg_wrdata(cfg_wrdata),
        .wr_cmd(wr_cmd), .src_valid(src_valid), .src_data(src_data),
        .src_mask(src_mask), .src_ecc(src_ecc), .src_ecc_mask(src_ecc_mask),
        .src_ready(src_ready), .phy_wd_en(phy_wd_en), .phy_wecc_en(phy_wecc_en),
        .phy_wd(phy_wd), .phy_wd_mask(phy_wd_mask), .phy_wecc(phy_wecc),
        .phy_wecc_mask(phy_wecc_mask), .underflow(underflow)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] fdat(input int tag, input int c);
        return {4'hA, 8'(tag), 24'(c * 7 + 1)};
    endfunction
    function automatic logic [MW-1:0] fmsk(input int tag, input int c);
        return MW'(c * 3 + tag);
    endfunction
    function automatic logic [ECC_W-1:0] fecc(input int tag, input int c);
        return ECC_W'(c * 5 + tag * 11);
    endfunction
    function automatic logic [EMW-1:0] femsk(input int tag, input int c);
        return EMW'(c + tag);
    endfunction

    // Drive one sequence of commands and check every output each cycle.
    task automatic run_seq(input int wrlat, input int wrdata, input logic [63:0] cmds,
                           input logic [15:0] ufs, input int tag);
        bit en_e[NC];
        bit due_e[NC];
        int bi = 0;
        for (int c = 0; c < NC; c++) begin
            en_e[c] = 1'b0;
            for (int k = 0; k < BURST; k++)
                if (c - wrlat - k >= 0 && cmds[c - wrlat - k]) en_e[c] = 1'b1;
            due_e[c] = (c - wrdata >= 0) ? en_e[c - wrdata] : 1'b0;
        end
        @(negedge clk);
        wr_cmd = 1'b0;
        cfg_wrlat = 4'(wrlat);
        cfg_wrdata = 3'(wrdata);
        repeat (30) @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            bit uf;
            uf = due_e[c] && ufs[bi];
            wr_cmd = cmds[c];
            src_valid = !uf;
            src_data = fdat(tag, c);
            src_mask = fmsk(tag, c);
            src_ecc = fecc(tag, c);
            src_ecc_mask = femsk(tag, c);
            #1;
            chk(phy_wd_en == (en_e[c] ? {SLICES{1'b1}} : '0), "R1 enable", 64'(phy_wd_en), 64'(en_e[c]));
            chk(phy_wecc_en == en_e[c], "R4 ecc enable", 64'(phy_wecc_en), 64'(en_e[c]));
            chk(src_ready == due_e[c], "R5 pop", 64'(src_ready), 64'(due_e[c]));
            chk(underflow == uf, "R7 underflow", 64'(underflow), 64'(uf));
            if (due_e[c] && !uf) begin
                chk(phy_wd == fdat(tag, c), "R2 data", 64'(phy_wd), 64'(fdat(tag, c)));
                chk(phy_wd_mask == fmsk(tag, c), "R6 mask", 64'(phy_wd_mask), 64'(fmsk(tag, c)));
                chk(phy_wecc == fecc(tag, c) && phy_wecc_mask == femsk(tag, c), "R5 ecc",
                    64'({phy_wecc, phy_wecc_mask}), 64'({fecc(tag, c), femsk(tag, c)}));
            end else if (uf) begin
                chk(phy_wd == '0 && phy_wecc == '0, "R7 data zero", 64'(phy_wd), 64'h0);
                chk(&phy_wd_mask && &phy_wecc_mask, "R7 full mask",
                    64'({phy_wd_mask, phy_wecc_mask}), 64'h7f);
            end else begin
                chk(phy_wd == '0 && phy_wd_mask == '0 && phy_wecc == '0 && phy_wecc_mask == '0,
                    "R8 quiet", 64'(phy_wd), 64'h0);
            end
            if (due_e[c]) bi++;
            @(negedge clk);
        end
        wr_cmd = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        // R9: reset state with command held low.
        repeat (3) @(negedge clk);
        #1;
        chk(phy_wd_en == '0 && !phy_wecc_en && !src_ready && !underflow, "R9 reset",
            64'({phy_wd_en, phy_wecc_en, src_ready, underflow}), 64'h0);
        rst_n = 1'b1;

        // Vector table walk: R1, R2, R5, R6, R7, R8.
        for (int v = 0; v < NV; v++)
            run_seq(V_LAT[v], V_OFS[v], 64'h1, 16'(V_UF[v]), v + 1);

        // R3: commands exactly one burst apart merge into one run.
        run_seq(2, 1, 64'h11, 16'h0, 20);
        run_seq(0, 0, 64'h111, 16'h0, 21);

        // R6: mask width and partial top byte.
        chk($bits(uut.phy_wd_mask) == 5 && $bits(uut.phy_wecc_mask) == 2, "R6 width",
            64'($bits(uut.phy_wd_mask)), 64'd5);
        @(negedge clk);
        cfg_wrlat = 4'd0; cfg_wrdata = 3'd0;
        repeat (30) @(negedge clk);
        wr_cmd = 1'b1; src_valid = 1'b1; src_mask = 5'b10000; src_data = 36'hF_0000_0000;
        #1;
        chk(phy_wd_mask == 5'b10000 && phy_wd[35:32] == 4'hF, "R6 top partial byte",
            64'(phy_wd_mask), 64'h10);
        @(negedge clk);
        wr_cmd = 1'b0;
        repeat (10) @(negedge clk);

        // R9: reset in the middle of a burst discards pending traffic.
        cfg_wrlat = 4'd3; cfg_wrdata = 3'd2;
        wr_cmd = 1'b1;
        @(negedge clk);
        wr_cmd = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk(phy_wd_en == '0 && !src_ready, "R9 mid-burst reset", 64'(phy_wd_en), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 12; c++) begin
            #1;
            chk(phy_wd_en == '0 && !src_ready && !underflow, "R9 nothing after reset",
                64'({phy_wd_en, src_ready}), 64'h0);
            @(negedge clk);
        end
        run_seq(1, 1, 64'h1, 16'h2, 30);

        $display("  Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end
endmodule